// File: doc/BRIEF.md
# OTP Page Programming Sequencer

This block is the host side of a one-time programmable memory writer. It drives the memory's parallel programming pins: a 17-bit address bus, an 8-bit data bus split into an output value, a drive enable and an input value, and three strobes, CE, OE and PGM. A start request gives a first and a last address and a mode. The bytes to program then arrive, in address order, over a ready/valid stream. The sequencer fills a small buffer and shapes every strobe edge. After each programming pulse it reads the cells back and compares them, and it retries the write when they do not match.

Two modes exist. In page mode, four address/data pairs are first latched into the memory. One timed PGM pulse then writes them, and all four bytes are read back. In byte mode, every byte gets its own pulse, followed by one read-back. Each unit is tried a limited number of times. The block then reports either completion or failure, and on failure it gives the first address that did not verify. The pulse length is a parameter counted in clock cycles. Supplies, the programming voltage and analog margins are outside this block.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, dev_ce, dev_oe and dev_pgm are 1 (pin high), dq_drive is 0, in_ready is 0, and done, fail and busy are 0.
- R2: A start pulse seen while idle captures page_mode (1 = page, 0 = byte), first_addr and last_addr. It then takes 4 bytes per page, or 1 byte in byte mode, from the stream, in rising address order. In page mode the two low address bits of first_addr and last_addr are ignored, so whole 4-byte pages from the page holding first_addr to the page holding last_addr are programmed. After done, every cell in that range holds its stream byte.
- R3: Page mode latches each byte with dev_addr[1:0] = 0,1,2,3 in turn, data driven, dev_ce = 1 and dev_pgm = 1. dev_oe is 0 for exactly one cycle, with one cycle of stable address and data before and after.
- R4: In page mode the write pulse holds dev_pgm at 0 for exactly PULSE_CYC cycles, with dev_ce = 1, dev_oe = 1 and the data bus not driven. The address during the pulse is the page base, whose low two bits are 0.
- R5: In byte mode the write pulse holds dev_pgm at 0 for exactly PULSE_CYC cycles, with dev_ce = 0, dev_oe = 1 and the byte's address and data driven.
- R6: Read-back uses dev_ce = 0, dev_oe = 0 and dev_pgm = 1. dq_drive is 0 in the cycle before dev_oe falls and stays 0 until dev_oe is high again.
- R7: If any byte of a unit reads back different from its stream byte, the unit is written and read again. In page mode the four bytes are latched again before the pulse. A unit gets at most MAX_TRIES (10) pulses, so a unit that matches on its tenth read-back still counts as a pass.
- R8: When the unit at last_addr verifies, done goes to 1 and busy to 0. done stays 1 until the next accepted start.
- R9: When a unit still mismatches after MAX_TRIES pulses, fail goes to 1 and fail_addr gives the lowest mismatching address of the last read-back. dev_ce, dev_oe and dev_pgm are then 1 and in_ready is 0, and this holds until the next start.
- R10: dev_pgm is never 0 while dev_oe is 0.
- R11: A start pulse while busy is 1 is ignored: the running job continues unchanged and none of the second request's cells are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a job (sampled only while idle) |
| page_mode | input | 1 | 1 = page mode, 0 = byte mode |
| first_addr | input | 17 | First address to program |
| last_addr | input | 17 | Last address to program |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Sequencer accepts a stream byte |
| dev_addr | output | 17 | Memory address pins |
| dq_out | output | 8 | Value driven on the memory data pins |
| dq_drive | output | 1 | Host data driver enable |
| dq_in | input | 8 | Value read from the memory data pins |
| dev_ce | output | 1 | CE pin level |
| dev_oe | output | 1 | OE pin level |
| dev_pgm | output | 1 | PGM pin level (low = program) |
| busy | output | 1 | A job is running |
| done | output | 1 | Last job completed |
| fail | output | 1 | Last job hit the retry limit |
| fail_addr | output | 17 | First failing address of the last attempt |

## Verification
Pass or fail is decided in a single cycle, at the end of each read-back. In that cycle the retry limit and the last-unit test can both apply, and a new start request can also arrive while the unit is in the middle of its pulse. The bench provokes the limit with a cell that needs exactly ten pulses, which must pass, and with a cell that never programs, which must stop the job with the right address. It also sends a second start during a running job. A memory model judges every outcome pulse by pulse: each expected pulse, with its address and data, is queued, and the queue must run empty with no pulse left over.

// File: rtl/otp_prog_pkg.sv
`timescale 1ns/1ps
package otp_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,
        ST_LSET,
        ST_LSTB,
        ST_LHLD,
        ST_WSET,
        ST_WPULSE,
        ST_WHLD,
        ST_VSET,
        ST_VRD,
        ST_VEND,
        ST_CHECK
    } seq_state_e;

    // pin levels of the memory strobes plus the host data driver enable
    typedef struct packed {
        logic ce;
        logic oe;
        logic pgm;
        logic drive;
    } strobe_t;

    localparam strobe_t STB_IDLE = '{ce: 1'b1, oe: 1'b1, pgm: 1'b1, drive: 1'b0};

endpackage

// File: rtl/otp_page_buf.sv
`timescale 1ns/1ps
module otp_page_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0][DATA_W-1:0] ents;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [DATA_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && wr_idx == IDX_W'(g)) begin
                ent_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ents[g] = ent_q;
    end

    assign rd_data = ents[rd_idx];

endmodule

// File: rtl/otp_pulse_timer.sv
`timescale 1ns/1ps
module otp_pulse_timer #(
    parameter int CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(CYCLES - 1);
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/otp_prog_seq.sv
`timescale 1ns/1ps
module otp_prog_seq
    import otp_prog_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 4,
    parameter int PULSE_CYC  = 25000,
    parameter int MAX_TRIES  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              page_mode,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    input  logic [DATA_W-1:0] dq_in,
    output logic              dev_ce,
    output logic              dev_oe,
    output logic              dev_pgm,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(PAGE_BYTES - 1);

    typedef struct packed {
        seq_state_e        state;
        logic              page;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] last;
        logic [IDX_W-1:0]  idx;
        logic [TRY_W-1:0]  tries;
        logic              mism;
        logic [ADDR_W-1:0] mism_addr;
        logic              done;
        logic              fail;
        logic [ADDR_W-1:0] fail_addr;
    } regs_t;

    regs_t q, d;

    logic              buf_we;
    logic [DATA_W-1:0] buf_rd;
    logic              tmr_load;
    logic              tmr_done;
    logic [IDX_W-1:0]  top_idx;
    logic [ADDR_W-1:0] unit_addr;
    logic              last_unit;
    strobe_t           stb;

    otp_page_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (PAGE_BYTES)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_idx  (q.idx),
        .wr_data (in_data),
        .rd_idx  (q.idx),
        .rd_data (buf_rd)
    );

    otp_pulse_timer #(
        .CYCLES (PULSE_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (q.state == ST_WPULSE),
        .expired (tmr_done)
    );

    // address of the byte currently addressed inside the unit
    assign unit_addr = q.page ? {q.base[ADDR_W-1:IDX_W], q.idx} : q.base;
    assign top_idx   = q.page ? TOP_IDX : '0;
    assign last_unit = q.page ? (q.base[ADDR_W-1:IDX_W] == q.last[ADDR_W-1:IDX_W])
                              : (q.base == q.last);

    always_comb begin
        d        = q;
        buf_we   = 1'b0;
        tmr_load = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_FILL;
                    d.page  = page_mode;
                    d.base  = page_mode ? {first_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}}
                                        : first_addr;
                    d.last  = last_addr;
                    d.idx   = '0;
                    d.done  = 1'b0;
                    d.fail  = 1'b0;
                end
            end
            ST_FILL: begin
                if (in_valid) begin
                    buf_we = 1'b1;
                    if (q.idx == top_idx) begin
                        d.idx   = '0;
                        d.tries = TRY_W'(1);
                        d.state = q.page ? ST_LSET : ST_WSET;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            ST_LSET: d.state = ST_LSTB;
            ST_LSTB: d.state = ST_LHLD;
            ST_LHLD: begin
                if (q.idx == top_idx) begin
                    d.idx   = '0;
                    d.state = ST_WSET;
                end else begin
                    d.idx   = q.idx + IDX_W'(1);
                    d.state = ST_LSET;
                end
            end
            ST_WSET: begin
                tmr_load = 1'b1;
                d.state  = ST_WPULSE;
            end
            ST_WPULSE: begin
                if (tmr_done) d.state = ST_WHLD;
            end
            ST_WHLD: begin
                d.idx   = '0;
                d.mism  = 1'b0;
                d.state = ST_VSET;
            end
            ST_VSET: d.state = ST_VRD;
            ST_VRD: begin
                if (dq_in != buf_rd && !q.mism) begin
                    d.mism      = 1'b1;
                    d.mism_addr = unit_addr;
                end
                d.state = ST_VEND;
            end
            ST_VEND: begin
                if (q.idx == top_idx) begin
                    d.state = ST_CHECK;
                end else begin
                    d.idx   = q.idx + IDX_W'(1);
                    d.state = ST_VSET;
                end
            end
            ST_CHECK: begin
                d.idx = '0;
                if (q.mism) begin
                    if (q.tries == TRY_W'(MAX_TRIES)) begin
                        d.fail      = 1'b1;
                        d.fail_addr = q.mism_addr;
                        d.state     = ST_IDLE;
                    end else begin
                        d.tries = q.tries + TRY_W'(1);
                        d.state = q.page ? ST_LSET : ST_WSET;
                    end
                end else if (last_unit) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.base  = q.base + (q.page ? ADDR_W'(PAGE_BYTES) : ADDR_W'(1));
                    d.state = ST_FILL;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    // strobe levels per phase
    always_comb begin
        stb = STB_IDLE;
        case (q.state)
            ST_LSET, ST_LHLD: stb.drive = 1'b1;
            ST_LSTB: begin
                stb.oe    = 1'b0;
                stb.drive = 1'b1;
            end
            ST_WSET, ST_WHLD: begin
                if (!q.page) begin
                    stb.ce    = 1'b0;
                    stb.drive = 1'b1;
                end
            end
            ST_WPULSE: begin
                stb.pgm = 1'b0;
                if (!q.page) begin
                    stb.ce    = 1'b0;
                    stb.drive = 1'b1;
                end
            end
            ST_VSET, ST_VEND: stb.ce = 1'b0;
            ST_VRD: begin
                stb.ce = 1'b0;
                stb.oe = 1'b0;
            end
            default: ;
        endcase
    end

    assign dev_ce    = stb.ce;
    assign dev_oe    = stb.oe;
    assign dev_pgm   = stb.pgm;
    assign dq_drive  = stb.drive;
    assign dq_out    = buf_rd;
    assign dev_addr  = unit_addr;
    assign in_ready  = (q.state == ST_FILL);
    assign busy      = (q.state != ST_IDLE);
    assign done      = q.done;
    assign fail      = q.fail;
    assign fail_addr = q.fail_addr;

    // ---------------- checks ----------------
    logic [CNT_W:0] low_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         low_cnt_q <= '0;
        else if (dev_pgm)                   low_cnt_q <= '0;
        else if (low_cnt_q != '1)           low_cnt_q <= low_cnt_q + 1'b1;
    end

    a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_pgm) |-> (low_cnt_q == (CNT_W+1)'(PULSE_CYC)));

    a_r4_page_pulse_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_pgm && q.page) |-> (dev_ce && !dq_drive));

    a_r5_byte_pulse_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_pgm && !q.page) |-> (!dev_ce && dq_drive));

    a_r6_release_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_oe && !dev_ce) |-> !$past(dq_drive));

    a_r10_no_pulse_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_pgm |-> dev_oe);

    a_r7_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.tries <= TRY_W'(MAX_TRIES));

    a_r9_fail_parks_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (dev_ce && dev_pgm && !in_ready));

    a_r8_done_fail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

endmodule

// File: tb/otp_prog_seq_test.sv
`timescale 1ns/1ps
module otp_prog_seq_test;
    localparam int AW    = 17;
    localparam int DW    = 8;
    localparam int PULSE = 6;
    localparam int MAXT  = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, start, page_mode, in_valid, in_ready;
    logic [AW-1:0] first_addr, last_addr, dev_addr, fail_addr;
    logic [DW-1:0] in_data, dq_out, dq_in;
    logic          dq_drive, dev_ce, dev_oe, dev_pgm, busy, done, fail;

    otp_prog_seq #(.PULSE_CYC(PULSE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_mode(page_mode),
        .first_addr(first_addr), .last_addr(last_addr),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .dev_addr(dev_addr), .dq_out(dq_out), .dq_drive(dq_drive), .dq_in(dq_in),
        .dev_ce(dev_ce), .dev_oe(dev_oe), .dev_pgm(dev_pgm),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem  [int];
    int         need [int];
    int         hits [int];

    function automatic logic [7:0] rd(input int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    function automatic logic [7:0] pat(input int a);
        return {1'b0, 7'(a) ^ 7'h2B};
    endfunction

    function automatic int need_of(input int a);
        return need.exists(a) ? need[a] : 1;
    endfunction

    task automatic program_cell(input int a, input logic [7:0] v);
        hits[a] = hits.exists(a) ? hits[a] + 1 : 1;
        if (hits[a] >= need_of(a)) mem[a] = rd(a) & v;
    endtask

    typedef struct packed {
        logic [31:0]     addr;
        logic            page;
        logic [3:0][7:0] d;
    } pulse_t;

    pulse_t     exp_q [$];
    logic [7:0] sq    [$];

    logic [3:0][7:0] latch;
    int  pw;
    bit  pgm_prev, drv_prev, pulse_bad, pulse_ce;

    // monitor: memory model plus scoreboard of programming pulses
    always @(negedge clk) begin
        pulse_t it;
        int     base;
        string  rq;
        if (!rst_n) begin
            pw = 0; pgm_prev = 1'b1; drv_prev = 1'b0; pulse_bad = 1'b0;
            dq_in = 8'hFF;
        end else begin
            if (dev_ce && dev_pgm && !dev_oe && dq_drive) latch[dev_addr[1:0]] = dq_out;
            if (!dev_ce && !dev_oe)
                check(!dq_drive && !drv_prev, "R6", "driver released around read",
                      {dq_drive, drv_prev}, 0);
            if (!dev_pgm) begin
                pw++;
                pulse_ce = dev_ce;
                if (!dev_oe) pulse_bad = 1'b1;
                if (dev_ce && dq_drive) pulse_bad = 1'b1;
                if (!dev_ce && !dq_drive) pulse_bad = 1'b1;
            end
            if (dev_pgm && !pgm_prev) begin
                rq = pulse_ce ? "R4" : "R5";
                check(pw == PULSE, rq, "pulse width", pw, PULSE);
                check(!pulse_bad, "R10", "strobe levels during pulse", pulse_bad, 0);
                base = pulse_ce ? (int'(dev_addr) & ~3) : int'(dev_addr);
                if (exp_q.size() == 0) begin
                    check(1'b0, rq, "unexpected pulse at address", base, 0);
                end else begin
                    it = exp_q.pop_front();
                    check(it.page == pulse_ce, rq, "pulse mode", pulse_ce, it.page);
                    check(base == int'(it.addr), rq, "pulse address", base, it.addr);
                    if (pulse_ce) begin
                        for (int i = 0; i < 4; i++)
                            check(latch[i] == it.d[i], "R3", "latched byte", latch[i], it.d[i]);
                    end else begin
                        check(dq_out == it.d[0], "R5", "byte data", dq_out, it.d[0]);
                    end
                end
                if (pulse_ce) begin
                    for (int i = 0; i < 4; i++) program_cell(base + i, latch[i]);
                end else begin
                    program_cell(base, dq_out);
                end
                pw = 0;
                pulse_bad = 1'b0;
            end
            pgm_prev = dev_pgm;
            drv_prev = dq_drive;
            dq_in = (!dev_ce && !dev_oe) ? rd(int'(dev_addr)) : 8'hFF;
        end
    end

    // stream driver
    bit took;
    always @(negedge clk) begin
        if (!rst_n) begin
            in_valid = 1'b0; in_data = '0; took = 1'b0;
        end else begin
            if (took) void'(sq.pop_front());
            in_valid = (sq.size() > 0);
            in_data  = in_valid ? sq[0] : '0;
            took     = in_valid && in_ready;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // driver: queues expected pulses and stream bytes, then runs one job
    task automatic run_job(input bit page, input int first, input int last);
        int u, n, att, bad, np, t, a0, a_end, mis, efa;
        bit ef;
        pulse_t it;
        ef = 1'b0; efa = 0;
        n  = page ? 4 : 1;
        u  = page ? (first & ~3) : first;
        a0 = u;
        forever begin
            att = 1; bad = -1;
            for (int i = 0; i < n; i++) begin
                sq.push_back(pat(u + i));
                if (need_of(u + i) > att) att = need_of(u + i);
                if (need_of(u + i) > MAXT && bad < 0) bad = u + i;
            end
            np = (att > MAXT) ? MAXT : att;
            it.addr = 32'(u); it.page = page; it.d = '0;
            for (int i = 0; i < n; i++) it.d[i] = pat(u + i);
            for (int k = 0; k < np; k++) exp_q.push_back(it);
            if (bad >= 0) begin ef = 1'b1; efa = bad; break; end
            if (page ? ((u >> 2) == (last >> 2)) : (u == last)) break;
            u += n;
        end
        a_end = u + n - 1;
        @(negedge clk);
        start = 1'b1; page_mode = page;
        first_addr = AW'(first); last_addr = AW'(last);
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!(done || fail) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(t < 20000, "R8", "job finished in time", t, 20000);
        check(fail == ef, "R9", "abort flag", fail, ef);
        check(done == !ef, "R8", "done flag", done, !ef);
        check(!busy, "R8", "busy after end", busy, 0);
        if (ef) check(int'(fail_addr) == efa, "R9", "failing address", fail_addr, efa);
        check(exp_q.size() == 0, "R7", "expected pulses left", exp_q.size(), 0);
        check(sq.size() == 0, "R2", "stream bytes left", sq.size(), 0);
        if (!ef) begin
            mis = 0;
            for (int a = a0; a <= a_end; a++) if (rd(a) != pat(a)) mis++;
            check(mis == 0, "R2", "cells not holding stream data", mis, 0);
        end
    endtask

    initial begin
        bit bsy;
        rst_n = 1'b0; start = 1'b0; page_mode = 1'b0;
        first_addr = '0; last_addr = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dev_ce && dev_oe && dev_pgm, "R1", "strobes after reset",
              {dev_ce, dev_oe, dev_pgm}, 7);
        check(!dq_drive && !in_ready, "R1", "driver and ready after reset",
              {dq_drive, in_ready}, 0);
        check(!done && !fail && !busy, "R1", "flags after reset", {done, fail, busy}, 0);

        // three clean pages
        run_job(1'b1, 32'h10, 32'h1B);
        repeat (5) @(negedge clk);
        check(done && !busy, "R8", "done held while idle", {done, busy}, 2);

        // unaligned range, weak cell, and a restart request while busy
        need[32'h105] = 3;
        fork
            run_job(1'b1, 32'h102, 32'h105);
            begin
                repeat (40) @(negedge clk);
                bsy = busy;
                start = 1'b1; page_mode = 1'b0;
                first_addr = AW'(32'h500); last_addr = AW'(32'h500);
                @(negedge clk);
                start = 1'b0;
            end
        join
        check(bsy, "R11", "sequencer busy at second start", bsy, 1);
        check(rd(32'h500) == 8'hFF, "R11", "second request cell untouched", rd(32'h500), 8'hFF);

        // byte mode at the top of the space; one cell needs the full ten pulses
        need[32'h1FFFE] = 10;
        need[32'h1FFFF] = 2;
        run_job(1'b0, 32'h1FFFE, 32'h1FFFF);

        // page that can never verify
        need[32'h209] = 99;
        run_job(1'b1, 32'h200, 32'h20B);
        repeat (20) @(negedge clk);
        check(fail && !done, "R9", "abort flag held", {fail, done}, 2);
        check(dev_ce && dev_oe && dev_pgm && !dq_drive, "R9", "parked strobes",
              {dev_ce, dev_oe, dev_pgm, dq_drive}, 14);
        check(!in_ready, "R9", "no stream intake after abort", in_ready, 0);
        check(int'(fail_addr) == 32'h209, "R9", "failing address held", fail_addr, 32'h209);

        // recovery with a plain byte-mode job
        run_job(1'b0, 32'h300, 32'h302);
        check(!fail, "R8", "abort flag cleared by new job", fail, 0);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule